// File: doc/BRIEF.md
# LCD Timing Generator with Shadowed Configuration

This block drives the control side of a parallel RGB LCD panel. It produces horizontal sync, vertical sync, a data-enable strobe and a pixel clock enable derived from the system clock by a programmable integer divider. Pixel data is not handled here. A downstream pixel path uses the data-enable and clock-enable outputs to know when to present each pixel.

Software programs the timing through a small register write port and can read the values back. Every timing field and the frame-synchronous control fields (run, divider select, divider value) land first in a shadow copy. The generator only ever runs from a live copy, which is refreshed from the shadow at the instant a new frame begins. A hold bit lets software update several registers without the generator picking up a half-written set. A frame interrupt with a selectable source, two enables and a write-one-to-clear pending flag signals frame progress to software.

Top module: `lcdtg_top`

## Requirements
- R1: A frame is a grid of H positions per line by V lines. H = hsync + hback + hactive + hfront and V = vsync + vback + vactive + vfront, where each term is the programmed field plus one. Each line runs sync, back porch, active, front porch in that order, and so does each frame. The horizontal fields are at address 2 (sync bits 7:0, back 15:8, front 23:16). The vertical fields are at address 3 in the same layout. Address 4 holds active pixels minus one in bits 10:0 and active lines minus one in bits 26:16. One frame lasts H*V*D clock cycles, where D is the divisor from R4.
- R2: Horizontal sync is active for the first hsync positions of every line, and vertical sync for the first vsync lines of a frame. Both are active-low when their invert bits are 0. Address 1 holds the invert bits: bit 0 hsync, bit 1 vsync, bit 2 data-enable. Polarity changes take effect at once.
- R3: Data-enable is active exactly on the hactive by vactive positions of the active region, for hactive*vactive*D cycles per frame. It is active-high when its invert bit is 0.
- R4: Address 0 holds run in bit 0, divider select in bit 1, divisor minus one in bits 15:8, and hold in bit 16. With divider select set, the pixel clock enable pulses once every (field+1) cycles, and a field of 255 is treated as 254 so the divisor stays between 1 and 255. With divider select clear, the enable is high every cycle. Either way, the grid advances one position per enable, H*V enables per frame.
- R5: Writes to the timing fields and to the run and divider fields reach the generator only at the next frame start. The current frame completes unchanged. Reads return the written (shadow) values.
- R6: While hold is set, no shadow-to-live copy takes place at a frame start. The first frame start after hold is cleared performs the copy.
- R7: With run set and hold clear, an idle generator starts a frame (vertical sync active) on the second clock edge after the write. Clearing run stops the generator after the current frame ends. While idle, syncs and data-enable sit at their inactive levels and the pixel clock enable is low.
- R8: Address 5 holds global interrupt enable (bit 0), frame interrupt enable (bit 1) and source select (bits 3:2). The pending flag (address 6, bit 0) sets on the selected event only while the frame enable is set. The interrupt output is pending AND global enable AND frame enable.
- R9: Source select 0 is the frame start (first cycle of vertical sync). Select 1 is the first active pixel of a frame. Select 2 is the first position after the last active pixel of the last active line. Select 3 is no source.
- R10: Writing 1 to bit 0 of address 6 clears the pending flag on the next cycle. Writing 0 there has no effect. A set in the same cycle wins over the clear.
- R11: After reset, all registers read 0, the generator is idle, both syncs are high, and data-enable, pixel clock enable and the interrupt output are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the pixel clock source |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data-enable |
| pix_ce_o | output | 1 | Pixel clock enable |
| irq_o | output | 1 | Frame interrupt |

## Verification
The sync, data-enable and clock-enable outputs are decoded combinationally from registered scan counters, so a new grid position shows up in the cycle after the edge where the clock enable was high. A run write is captured into the shadow at one edge and the frame starts at the next edge. A pending set and the grid position that triggers it appear in the same cycle, and a clear write takes effect one edge later. The bench drives every input at the falling edge and reads every output at the falling edge. Frame timing is measured as cycle counts between sync edges, so each result is compared against the H*V*D arithmetic with no dependence on phase. Deferred updates are checked frame by frame: the frame in which a write lands is measured, then the frame that follows.

// File: rtl/lcdtg_pkg.sv
package lcdtg_pkg;
    localparam int PW  = 8;        // porch / sync field width
    localparam int AW  = 11;       // active size field width
    localparam int DW  = 8;        // divider field width
    localparam int XW  = 32;       // register data width
    localparam int RAW = 3;        // register address width
    localparam int CW  = AW + 2;   // scan counter width

    localparam logic [RAW-1:0] A_CTRL  = 3'd0;
    localparam logic [RAW-1:0] A_POL   = 3'd1;
    localparam logic [RAW-1:0] A_HTIM  = 3'd2;
    localparam logic [RAW-1:0] A_VTIM  = 3'd3;
    localparam logic [RAW-1:0] A_SIZE  = 3'd4;
    localparam logic [RAW-1:0] A_ICTL  = 3'd5;
    localparam logic [RAW-1:0] A_IPEND = 3'd6;

    typedef struct packed {
        logic [PW-1:0] sync;
        logic [PW-1:0] back;
        logic [PW-1:0] front;
        logic [AW-1:0] act;
    } axis_t;

    typedef struct packed {
        logic          run;
        logic          div_sel;
        logic [DW-1:0] div_m1;
        axis_t         h;
        axis_t         v;
    } tcfg_t;

    typedef struct packed {
        logic hs_inv;
        logic vs_inv;
        logic de_inv;
    } pol_t;

    typedef struct packed {
        logic       gen;
        logic       fen;
        logic [1:0] sel;
    } ictl_t;
endpackage

// File: rtl/lcdtg_regs.sv
module lcdtg_regs
    import lcdtg_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [RAW-1:0] wr_addr,
    input  logic [XW-1:0]  wr_data,
    input  logic [RAW-1:0] rd_addr,
    input  logic           commit,
    input  logic           pend,
    output tcfg_t          shadow,
    output tcfg_t          live,
    output logic           hold,
    output pol_t           pol,
    output ictl_t          ictl,
    output logic [XW-1:0]  rd_data
);
    typedef struct packed {
        tcfg_t sh;
        tcfg_t lv;
        logic  hold;
        pol_t  pol;
        ictl_t ictl;
    } rstate_t;

    rstate_t st_d, st_q;
    logic    unused_bits;

    assign unused_bits = ^{wr_data[31:27], wr_data[26:16], wr_data[15:0]};

    always_comb begin
        st_d = st_q;
        if (commit) begin
            st_d.lv = st_q.sh;
        end
        if (wr_en) begin
            case (wr_addr)
                A_CTRL: begin
                    st_d.sh.run     = wr_data[0];
                    st_d.sh.div_sel = wr_data[1];
                    st_d.sh.div_m1  = wr_data[8 +: DW];
                    st_d.hold       = wr_data[16];
                end
                A_POL: begin
                    st_d.pol.hs_inv = wr_data[0];
                    st_d.pol.vs_inv = wr_data[1];
                    st_d.pol.de_inv = wr_data[2];
                end
                A_HTIM: begin
                    st_d.sh.h.sync  = wr_data[0 +: PW];
                    st_d.sh.h.back  = wr_data[8 +: PW];
                    st_d.sh.h.front = wr_data[16 +: PW];
                end
                A_VTIM: begin
                    st_d.sh.v.sync  = wr_data[0 +: PW];
                    st_d.sh.v.back  = wr_data[8 +: PW];
                    st_d.sh.v.front = wr_data[16 +: PW];
                end
                A_SIZE: begin
                    st_d.sh.h.act = wr_data[0 +: AW];
                    st_d.sh.v.act = wr_data[16 +: AW];
                end
                A_ICTL: begin
                    st_d.ictl.gen = wr_data[0];
                    st_d.ictl.fen = wr_data[1];
                    st_d.ictl.sel = wr_data[3:2];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CTRL: begin
                rd_data[0]       = st_q.sh.run;
                rd_data[1]       = st_q.sh.div_sel;
                rd_data[8 +: DW] = st_q.sh.div_m1;
                rd_data[16]      = st_q.hold;
            end
            A_POL: begin
                rd_data[0] = st_q.pol.hs_inv;
                rd_data[1] = st_q.pol.vs_inv;
                rd_data[2] = st_q.pol.de_inv;
            end
            A_HTIM: begin
                rd_data[0 +: PW]  = st_q.sh.h.sync;
                rd_data[8 +: PW]  = st_q.sh.h.back;
                rd_data[16 +: PW] = st_q.sh.h.front;
            end
            A_VTIM: begin
                rd_data[0 +: PW]  = st_q.sh.v.sync;
                rd_data[8 +: PW]  = st_q.sh.v.back;
                rd_data[16 +: PW] = st_q.sh.v.front;
            end
            A_SIZE: begin
                rd_data[0 +: AW]  = st_q.sh.h.act;
                rd_data[16 +: AW] = st_q.sh.v.act;
            end
            A_ICTL: begin
                rd_data[0]   = st_q.ictl.gen;
                rd_data[1]   = st_q.ictl.fen;
                rd_data[3:2] = st_q.ictl.sel;
            end
            A_IPEND: rd_data[0] = pend;
            default: ;
        endcase
    end

    assign shadow = st_q.sh;
    assign live   = st_q.lv;
    assign hold   = st_q.hold;
    assign pol    = st_q.pol;
    assign ictl   = st_q.ictl;
endmodule

// File: rtl/lcdtg_clkdiv.sv
module lcdtg_clkdiv
    import lcdtg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          restart,
    input  logic          div_sel,
    input  logic [DW-1:0] div_m1,
    output logic          ce
);
    typedef struct packed {
        logic [DW-1:0] cnt;
    } dstate_t;

    dstate_t       st_d, st_q;
    logic [DW-1:0] lim;
    logic [DW-1:0] clamped;

    always_comb begin
        clamped = (div_m1 == {DW{1'b1}}) ? (div_m1 - DW'(1)) : div_m1;
        lim     = div_sel ? clamped : '0;
        ce      = run && (st_q.cnt == lim);
        st_d    = st_q;
        if (!run || restart || ce) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + DW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/lcdtg_scan.sv
module lcdtg_scan
    import lcdtg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  axis_t lh,
    input  axis_t lv,
    input  logic  live_run,
    input  logic  sh_run,
    input  logic  hold,
    input  logic  ce,
    output logic  run,
    output logic  commit,
    output logic  hs_act,
    output logic  vs_act,
    output logic  de_act,
    output logic  evt_frame,
    output logic  evt_act,
    output logic  evt_end
);
    typedef struct packed {
        logic          run;
        logic [CW-1:0] hc;
        logic [CW-1:0] vc;
    } sstate_t;

    sstate_t       st_d, st_q;
    logic [CW-1:0] h_s, h_a, h_e, h_t;
    logic [CW-1:0] v_s, v_a, v_e, v_t;
    logic          h_last, v_last, adv;

    always_comb begin
        h_s = CW'(lh.sync) + CW'(1);
        h_a = h_s + CW'(lh.back) + CW'(1);
        h_e = h_a + CW'(lh.act) + CW'(1);
        h_t = h_e + CW'(lh.front) + CW'(1);
        v_s = CW'(lv.sync) + CW'(1);
        v_a = v_s + CW'(lv.back) + CW'(1);
        v_e = v_a + CW'(lv.act) + CW'(1);
        v_t = v_e + CW'(lv.front) + CW'(1);
        h_last = (st_q.hc == h_t - CW'(1));
        v_last = (st_q.vc == v_t - CW'(1));

        st_d      = st_q;
        commit    = 1'b0;
        evt_frame = 1'b0;
        if (!st_q.run) begin
            if (sh_run && !hold) begin
                commit    = 1'b1;
                st_d.run  = 1'b1;
                st_d.hc   = '0;
                st_d.vc   = '0;
                evt_frame = 1'b1;
            end
        end else if (ce) begin
            if (h_last) begin
                st_d.hc = '0;
                if (v_last) begin
                    st_d.vc = '0;
                    if (!hold) begin
                        commit   = 1'b1;
                        st_d.run = sh_run;
                    end else begin
                        st_d.run = live_run;
                    end
                    evt_frame = st_d.run;
                end else begin
                    st_d.vc = st_q.vc + CW'(1);
                end
            end else begin
                st_d.hc = st_q.hc + CW'(1);
            end
        end

        adv     = st_q.run && ce && st_d.run;
        evt_act = adv && (st_d.hc == h_a) && (st_d.vc == v_a);
        evt_end = adv && (st_d.hc == h_e) && (st_d.vc == v_e - CW'(1));

        hs_act = st_q.run && (st_q.hc < h_s);
        vs_act = st_q.run && (st_q.vc < v_s);
        de_act = st_q.run && (st_q.hc >= h_a) && (st_q.hc < h_e)
                          && (st_q.vc >= v_a) && (st_q.vc < v_e);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign run = st_q.run;
endmodule

// File: rtl/lcdtg_irq.sv
module lcdtg_irq
    import lcdtg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  evt_frame,
    input  logic  evt_act,
    input  logic  evt_end,
    input  ictl_t ictl,
    input  logic  w1c,
    output logic  hit,
    output logic  pend,
    output logic  irq
);
    typedef struct packed {
        logic pend;
    } istate_t;

    istate_t st_d, st_q;
    logic    src;

    always_comb begin
        case (ictl.sel)
            2'd0:    src = evt_frame;
            2'd1:    src = evt_act;
            2'd2:    src = evt_end;
            default: src = 1'b0;
        endcase
        hit       = ictl.fen && src;
        st_d      = st_q;
        st_d.pend = hit || (st_q.pend && !w1c);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend = st_q.pend;
    assign irq  = st_q.pend && ictl.gen && ictl.fen;
endmodule

// File: rtl/lcdtg_top.sv
module lcdtg_top
    import lcdtg_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [RAW-1:0] wr_addr,
    input  logic [XW-1:0]  wr_data,
    input  logic [RAW-1:0] rd_addr,
    output logic [XW-1:0]  rd_data,
    output logic           hsync_o,
    output logic           vsync_o,
    output logic           de_o,
    output logic           pix_ce_o,
    output logic           irq_o
);
    tcfg_t shadow_w, live_w;
    pol_t  pol_w;
    ictl_t ictl_w;
    logic  hold_w, commit_w, run_w, ce_w;
    logic  hs_act_w, vs_act_w, de_act_w;
    logic  ev_frame_w, ev_act_w, ev_end_w;
    logic  pend_w, hit_w, w1c_w;

    assign w1c_w = wr_en && (wr_addr == A_IPEND) && wr_data[0];

    lcdtg_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .commit(commit_w), .pend(pend_w),
        .shadow(shadow_w), .live(live_w), .hold(hold_w),
        .pol(pol_w), .ictl(ictl_w), .rd_data(rd_data)
    );

    lcdtg_clkdiv u_div (
        .clk(clk), .rst_n(rst_n), .run(run_w), .restart(commit_w),
        .div_sel(live_w.div_sel), .div_m1(live_w.div_m1), .ce(ce_w)
    );

    lcdtg_scan u_scan (
        .clk(clk), .rst_n(rst_n), .lh(live_w.h), .lv(live_w.v),
        .live_run(live_w.run), .sh_run(shadow_w.run), .hold(hold_w),
        .ce(ce_w), .run(run_w), .commit(commit_w),
        .hs_act(hs_act_w), .vs_act(vs_act_w), .de_act(de_act_w),
        .evt_frame(ev_frame_w), .evt_act(ev_act_w), .evt_end(ev_end_w)
    );

    lcdtg_irq u_irq (
        .clk(clk), .rst_n(rst_n), .evt_frame(ev_frame_w),
        .evt_act(ev_act_w), .evt_end(ev_end_w), .ictl(ictl_w),
        .w1c(w1c_w), .hit(hit_w), .pend(pend_w), .irq(irq_o)
    );

    assign hsync_o  = ~(hs_act_w ^ pol_w.hs_inv);
    assign vsync_o  = ~(vs_act_w ^ pol_w.vs_inv);
    assign de_o     = de_act_w ^ pol_w.de_inv;
    assign pix_ce_o = ce_w;
endmodule

// File: rtl/lcdtg_chk.sv
module lcdtg_chk
    import lcdtg_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic           run,
    input logic           commit,
    input logic           hold,
    input logic           de_act,
    input logic           pix_ce,
    input logic           hsync_o,
    input pol_t           pol,
    input ictl_t          ictl,
    input logic           pend,
    input logic           hit,
    input logic           irq_o,
    input logic           wr_en,
    input logic [RAW-1:0] wr_addr,
    input logic [XW-1:0]  wr_data
);
    // R6
    commit_blocked_by_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !hold);

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (!de_act && !pix_ce && (hsync_o == !pol.hs_inv)));

    // R7
    stop_at_frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run) |-> $past(commit));

    // R8
    irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (pend && ictl.gen && ictl.fen));

    // R10
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_IPEND && wr_data[0] && !hit) |=> !pend);

    // R10
    pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !(wr_en && wr_addr == A_IPEND && wr_data[0])) |=> pend);
endmodule

bind lcdtg_top lcdtg_chk u_chk (
    .clk(clk), .rst_n(rst_n), .run(run_w), .commit(commit_w),
    .hold(hold_w), .de_act(de_act_w), .pix_ce(pix_ce_o),
    .hsync_o(hsync_o), .pol(pol_w), .ictl(ictl_w), .pend(pend_w),
    .hit(hit_w), .irq_o(irq_o), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data)
);

// File: tb/lcdtg_top_tb.sv
`timescale 1ns/1ps
module lcdtg_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        hsync, vsync, de, pix_ce, irq;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit hinv = 0, vinv = 0, dinv = 0;
    int m_per, m_de, m_hs, m_vs, m_ce;
    bit m_found;

    // columns: hs hbp hact hfp vs vbp vact vfp divsel divm1 frame_cycles
    localparam int NV = 5;
    localparam int VEC [NV][11] = '{
        '{2, 3, 8, 2, 1, 2, 4, 1, 0, 0, 120},
        '{1, 1, 4, 1, 2, 1, 3, 2, 1, 2, 168},
        '{3, 2, 6, 4, 1, 1, 2, 1, 0, 7, 75},
        '{1, 1, 1, 1, 1, 1, 1, 1, 1, 255, 4080},
        '{4, 4, 16, 4, 2, 2, 6, 2, 1, 0, 336}
    };

    lcdtg_top u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .hsync_o(hsync), .vsync_o(vsync), .de_o(de), .pix_ce_o(pix_ce),
        .irq_o(irq)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog (R7) actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic bit vs_on();
        return vsync == vinv;
    endfunction
    function automatic bit hs_on();
        return hsync == hinv;
    endfunction
    function automatic bit de_on();
        return de != dinv;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr_en = 1'b0; hinv = 0; vinv = 0; dinv = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_edge(input int maxc, output bit f);
        bit p;
        f = 0;
        p = vs_on();
        for (int k = 0; k < maxc; k++) begin
            @(negedge clk);
            if (vs_on() && !p) begin
                f = 1;
                return;
            end
            p = vs_on();
        end
    endtask

    // counts one frame from a vsync active edge to the next one
    task automatic measure(input bit chain, input int maxc, input bit mw,
                           input logic [2:0] ma, input logic [31:0] md);
        bit f, p;
        m_per = 0; m_de = 0; m_hs = 0; m_vs = 0; m_ce = 0; m_found = 0;
        if (!chain) begin
            wait_edge(maxc, f);
            if (!f) return;
        end
        for (int k = 0; k < maxc; k++) begin
            if (mw && k == 5) begin
                wr_en = 1'b1; wr_addr = ma; wr_data = md;
            end else begin
                wr_en = 1'b0;
            end
            m_per++;
            if (de_on()) m_de++;
            if (hs_on()) m_hs++;
            if (vs_on()) m_vs++;
            if (pix_ce) m_ce++;
            p = vs_on();
            @(negedge clk);
            if (vs_on() && !p) begin
                m_found = 1;
                wr_en = 1'b0;
                return;
            end
        end
        wr_en = 1'b0;
    endtask

    function automatic logic [31:0] htim(input int s, input int b, input int f);
        return 32'(s - 1) | (32'(b - 1) << 8) | (32'(f - 1) << 16);
    endfunction

    initial begin
        logic [31:0] r;
        bit f, pi, pd, dn;
        int rises;

        do_reset();
        // R11 reset state
        chk("R11 hsync idle", int'(hsync), 1);
        chk("R11 vsync idle", int'(vsync), 1);
        chk("R11 de idle", int'(de), 0);
        chk("R11 pix_ce idle", int'(pix_ce), 0);
        chk("R11 irq idle", int'(irq), 0);
        rd(3'd0, r);
        chk("R11 ctrl reads 0", int'(r), 0);
        rd(3'd2, r);
        chk("R11 htim reads 0", int'(r), 0);

        // vector table: R1 R2 R3 R4
        for (int i = 0; i < NV; i++) begin
            int h, v, d, m1;
            do_reset();
            h  = VEC[i][0] + VEC[i][1] + VEC[i][2] + VEC[i][3];
            v  = VEC[i][4] + VEC[i][5] + VEC[i][6] + VEC[i][7];
            m1 = (VEC[i][9] == 255) ? 254 : VEC[i][9];
            d  = (VEC[i][8] != 0) ? m1 + 1 : 1;
            wr(3'd2, htim(VEC[i][0], VEC[i][1], VEC[i][3]));
            wr(3'd3, htim(VEC[i][4], VEC[i][5], VEC[i][7]));
            wr(3'd4, 32'(VEC[i][2] - 1) | (32'(VEC[i][6] - 1) << 16));
            wr(3'd0, 32'd1 | (32'(VEC[i][8]) << 1) | (32'(VEC[i][9]) << 8));
            measure(0, 20000, 0, 3'd0, 32'd0);
            chk("R1 frame found", int'(m_found), 1);
            chk("R1 frame cycles", m_per, VEC[i][10]);
            chk("R2 hsync active cycles", m_hs, VEC[i][0] * v * d);
            chk("R2 vsync active cycles", m_vs, VEC[i][4] * h * d);
            chk("R3 de active cycles", m_de, VEC[i][2] * VEC[i][6] * d);
            chk("R4 pixel enables per frame", m_ce, h * v);
        end

        // R7 start two edges after run write
        do_reset();
        wr(3'd2, htim(2, 3, 2));
        wr(3'd3, htim(1, 2, 1));
        wr(3'd4, 32'(8 - 1) | (32'(4 - 1) << 16));
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd0; wr_data = 32'd1;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R7 not started after one edge", int'(vs_on()), 0);
        @(negedge clk);
        chk("R7 vsync active after second edge", int'(vs_on()), 1);

        // R5 mid-frame write deferred to next frame
        measure(0, 1000, 1, 3'd2, htim(2, 3, 5));
        chk("R5 frame with mid write unchanged", m_per, 120);
        rd(3'd2, r);
        chk("R5 readback shadow", int'(r), int'(htim(2, 3, 5)));
        measure(1, 1000, 0, 3'd0, 32'd0);
        chk("R5 next frame uses new value", m_per, 144);

        // R6 hold defers the copy
        measure(1, 1000, 1, 3'd0, 32'h0001_0001);
        chk("R6 frame after hold set", m_per, 144);
        measure(1, 1000, 1, 3'd2, htim(2, 3, 2));
        chk("R6 held frame A", m_per, 144);
        measure(1, 1000, 0, 3'd0, 32'd0);
        chk("R6 held frame B", m_per, 144);
        measure(1, 1000, 1, 3'd0, 32'h0000_0001);
        chk("R6 frame in which hold clears", m_per, 144);
        measure(1, 1000, 0, 3'd0, 32'd0);
        chk("R6 copy after hold clear", m_per, 120);

        // R8 frame enable required
        wr(3'd5, 32'h1);
        wait_edge(1000, f);
        chk("R8 no irq without frame enable", int'(irq), 0);
        rd(3'd6, r);
        chk("R8 no pending without frame enable", int'(r), 0);
        // R9 select 0: frame start
        wr(3'd5, 32'h3);
        wait_edge(1000, f);
        chk("R9 irq at vsync start", int'(irq), 1);
        // R10 write-one-to-clear
        wr(3'd6, 32'h0);
        chk("R10 write zero keeps pending", int'(irq), 1);
        wr(3'd6, 32'h1);
        chk("R10 write one clears", int'(irq), 0);
        // R8 global enable gates output only
        wr(3'd5, 32'h2);
        wait_edge(1000, f);
        chk("R8 irq masked by global enable", int'(irq), 0);
        rd(3'd6, r);
        chk("R8 pending set while masked", int'(r), 1);

        // R9 select 1: first active pixel
        wait_edge(1000, f);
        wr(3'd6, 32'h1);
        wr(3'd5, 32'h7);
        pi = irq;
        for (int k = 0; k < 500; k++) begin
            @(negedge clk);
            if (de_on()) break;
            pi = irq;
        end
        chk("R9 sel1 irq low before first pixel", int'(pi), 0);
        chk("R9 sel1 irq at first pixel", int'(irq), 1);

        // R9 select 2: end of active region
        wait_edge(1000, f);
        wr(3'd6, 32'h1);
        wr(3'd5, 32'hB);
        rises = 0;
        pd = de_on();
        dn = pd;
        for (int k = 0; k < 500; k++) begin
            @(negedge clk);
            dn = de_on();
            if (dn && !pd) rises++;
            if (irq) break;
            pd = dn;
        end
        chk("R9 sel2 after all active lines", rises, 4);
        chk("R9 sel2 de just ended", int'({pd, dn}), 2);

        // R9 select 3: no source
        wait_edge(1000, f);
        wr(3'd6, 32'h1);
        wr(3'd5, 32'hF);
        rises = 0;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (irq) rises++;
        end
        chk("R9 sel3 never fires", rises, 0);
        wr(3'd5, 32'h0);

        // R2 R3 inverted polarity
        wr(3'd1, 32'h7);
        hinv = 1; vinv = 1; dinv = 1;
        measure(0, 1000, 0, 3'd0, 32'd0);
        chk("R2 inverted hsync cycles", m_hs, 16);
        chk("R2 inverted vsync cycles", m_vs, 15);
        chk("R3 inverted de cycles", m_de, 32);
        wr(3'd1, 32'h0);
        hinv = 0; vinv = 0; dinv = 0;

        // R7 stop at end of frame
        measure(0, 240, 1, 3'd0, 32'h0);
        chk("R7 no new frame after stop", int'(m_found), 0);
        chk("R7 current frame completes", m_de, 32);
        chk("R7 pix_ce low when idle", int'(pix_ce), 0);
        chk("R7 hsync inactive when idle", int'(hsync), 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule